// File: doc/BRIEF.md
# One-Time-Programmable Byte Store: Mode and Timing Model

This block is a clocked, synthesizable behavioural stand-in for an 8192 x 8 ultraviolet-erasable read-only memory. It serves as the target device in testbenches for memory controllers and programmers. Each clock edge it samples the control pins: active-low chip enable, output enable and program strobe, plus a programming-supply flag (`vpp_hi`) and a high-voltage flag on address bit 9 (`a9_hv`). From these it picks one of seven operating modes, and it drives the data bus only in the three modes that return data.

Read data appears a parameterised number of cycles after an access starts. The bus stays driven for a separate float count after the access ends. Programming can only clear bits, because each program cycle ANDs the input byte into the addressed location. An identity mode returns one of two parameter-set codes in place of array contents.

The output side is a four-state machine:

| State | Meaning |
|---|---|
| ST_OFF | Bus released. |
| ST_WAIT | Access timer running; bus released. |
| ST_VALID | Byte driven. |
| ST_FLOAT | Previous byte still driven while the release timer runs. |

Its transitions are:

| From | To | Condition |
|---|---|---|
| ST_OFF | ST_WAIT | A data mode is sampled. |
| ST_WAIT | ST_OFF | The data mode is left. |
| ST_WAIT | ST_WAIT | The timer reloads because the mode or address changed. |
| ST_WAIT | ST_VALID | The timer expires; the byte is captured. |
| ST_VALID | ST_WAIT | The mode or address changed. |
| ST_VALID | ST_FLOAT | The data mode is left. When the float count is zero, the machine goes straight to ST_OFF. |
| ST_FLOAT | ST_WAIT | A data mode returns. |
| ST_FLOAT | ST_OFF | The release timer expires. |

Top module: `eprom_mode_model`

## Requirements
- R1: The store has 8192 distinct byte locations selected by the 13-bit `addr`. After reset (`rst_n` low, asynchronous), every location reads 0xFF and `dout_en` is 0.
- R2: Read mode is `ce_n`=0, `oe_n`=0, `pgm_n`=1, `vpp_hi`=0 and `a9_hv`=0. Suppose a data mode is first sampled at edge k and mode and address stay unchanged through edge k+ACCESS_CYC (default 3). Then `dout_en` rises after edge k+ACCESS_CYC and `dout` carries the addressed byte. A change of address or mode while in a data mode drops `dout_en` and restarts the wait.
- R3: Program mode is `ce_n`=0, `oe_n`=1, `pgm_n`=0 and `vpp_hi`=1. At each edge in this mode the addressed byte becomes its old value AND `din`. The bus is never enabled by this mode.
- R4: Verify mode is `ce_n`=0, `oe_n`=0, `pgm_n`=1 and `vpp_hi`=1. It returns the stored byte with the R2 timing, whatever `a9_hv` is.
- R5: With `ce_n`=1 (standby when `vpp_hi`=0, program-inhibit when `vpp_hi`=1), no access starts and no location changes, whatever `oe_n`, `pgm_n` and `din` are.
- R6: Output-disable (`ce_n`=0, `oe_n`=1, `pgm_n`=1, `vpp_hi`=0) and every undecoded combination start no access and change no location.
- R7: Identity mode is the read-mode pin pattern with `a9_hv`=1. With `addr[0]`=0 it returns MFR_ID (default 0xA5); with `addr[0]`=1 it returns DEV_ID (default 0x3C). It uses the R2 timing.
- R8: When a data mode ends while the byte is driven, `dout_en` stays 1 with the same `dout` for FLOAT_CYC edges (default 2), then falls. If a data mode is sampled inside that window, the window ends at once and a new wait starts.
- R9: While `dout_en` stays 1 across consecutive cycles, `dout` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; restores the erased array |
| addr | input | 13 | Byte address; bit 0 also picks the identity code |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply at high level |
| a9_hv | input | 1 | High voltage present on address bit 9 |
| din | input | 8 | Byte to program |
| dout | output | 8 | Byte returned |
| dout_en | output | 1 | Drive enable for the tri-state data bus |

## Verification
Two functions can fall in the same cycle: the release window of a finished access, and the start of the next access. The bench provokes this by raising output enable for a single cycle after a byte is valid, and by changing the address while a byte is driven. In the first case the release countdown and a fresh access wait compete at one edge. A behavioural reference keeps its own cycle counts and a model of the store, and it judges every clock. The expected rule is that the new access wins immediately: the bus drops in that cycle and comes back ACCESS_CYC edges later with the new byte.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    typedef enum logic [2:0] {
        MD_READ,
        MD_PROGRAM,
        MD_VERIFY,
        MD_INHIBIT,
        MD_STANDBY,
        MD_OUTDIS,
        MD_IDENT,
        MD_ILLEGAL
    } mode_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_WAIT,
        ST_VALID,
        ST_FLOAT
    } out_state_e;

    function automatic mode_e decode_mode(input logic ce_n, input logic oe_n,
                                          input logic pgm_n, input logic vpp_hi,
                                          input logic a9_hv);
        mode_e m;
        if (ce_n)
            m = vpp_hi ? MD_INHIBIT : MD_STANDBY;
        else if (vpp_hi) begin
            if (oe_n && !pgm_n)      m = MD_PROGRAM;
            else if (!oe_n && pgm_n) m = MD_VERIFY;
            else                     m = MD_ILLEGAL;
        end else begin
            if (oe_n && pgm_n)       m = MD_OUTDIS;
            else if (!oe_n && pgm_n) m = a9_hv ? MD_IDENT : MD_READ;
            else                     m = MD_ILLEGAL;
        end
        return m;
    endfunction

endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
    import eprom_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  pgm_n,
    input  logic  vpp_hi,
    input  logic  a9_hv,
    output mode_e mode,
    output logic  drive_req,
    output logic  wr_en,
    output logic  ident_sel
);
    always_comb begin
        mode      = decode_mode(ce_n, oe_n, pgm_n, vpp_hi, a9_hv);
        drive_req = (mode == MD_READ) || (mode == MD_VERIFY) || (mode == MD_IDENT);
        wr_en     = (mode == MD_PROGRAM);
        ident_sel = (mode == MD_IDENT);
    end
endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Erased state is all ones; a program cycle can only clear bits.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (wr_en) begin
            cells[addr] <= cells[addr] & wr_data;
        end
    end

    assign rd_data = cells[addr];
endmodule

// File: rtl/eprom_out_fsm.sv
module eprom_out_fsm
    import eprom_pkg::*;
#(
    parameter int DW         = 8,
    parameter int KW         = 16,
    parameter int ACCESS_CYC = 3,
    parameter int FLOAT_CYC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drive_req,
    input  logic [KW-1:0] key,
    input  logic [DW-1:0] rd_sel,
    output logic [DW-1:0] dout,
    output logic          dout_en
);
    localparam int MAXC   = (ACCESS_CYC > FLOAT_CYC) ? ACCESS_CYC : FLOAT_CYC;
    localparam int CW     = $clog2(MAXC + 2);
    localparam logic [CW-1:0] ACC_LD = CW'(ACCESS_CYC);
    localparam logic [CW-1:0] FLT_LD = CW'(FLOAT_CYC);
    localparam logic [CW-1:0] ONE    = CW'(1);

    out_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [KW-1:0] key_q;
    logic [DW-1:0] data_q;
    logic          capture;
    logic          key_moved;

    assign key_moved = (key != key_q);

    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        capture = 1'b0;
        unique case (st_q)
            ST_OFF: begin
                if (drive_req) begin
                    st_d  = ST_WAIT;
                    cnt_d = ACC_LD;
                end
            end
            ST_WAIT: begin
                if (!drive_req) begin
                    st_d = ST_OFF;
                end else if (key_moved) begin
                    cnt_d = ACC_LD;
                end else if (cnt_q <= ONE) begin
                    st_d    = ST_VALID;
                    capture = 1'b1;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            ST_VALID: begin
                if (!drive_req) begin
                    st_d  = (FLOAT_CYC == 0) ? ST_OFF : ST_FLOAT;
                    cnt_d = FLT_LD;
                end else if (key_moved) begin
                    st_d  = ST_WAIT;
                    cnt_d = ACC_LD;
                end
            end
            ST_FLOAT: begin
                if (drive_req) begin
                    st_d  = ST_WAIT;
                    cnt_d = ACC_LD;
                end else if (cnt_q <= ONE) begin
                    st_d = ST_OFF;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_OFF;
            cnt_q  <= '0;
            key_q  <= '0;
            data_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            key_q <= key;
            if (capture) data_q <= rd_sel;
        end
    end

    always_comb begin
        dout_en = (st_q == ST_VALID) || (st_q == ST_FLOAT);
        dout    = data_q;
    end
endmodule

// File: rtl/eprom_mode_model.sv
module eprom_mode_model
    import eprom_pkg::*;
#(
    parameter int            AW         = 13,
    parameter int            DW         = 8,
    parameter int            ACCESS_CYC = 3,
    parameter int            FLOAT_CYC  = 2,
    parameter logic [DW-1:0] MFR_ID     = 8'hA5,
    parameter logic [DW-1:0] DEV_ID     = 8'h3C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          pgm_n,
    input  logic          vpp_hi,
    input  logic          a9_hv,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en
);
    localparam int KW = AW + 3;

    mode_e         mode;
    logic          drive_req;
    logic          wr_en;
    logic          ident_sel;
    logic [DW-1:0] arr_rd;
    logic [DW-1:0] rd_sel;
    logic [KW-1:0] key;

    eprom_mode_decode u_dec (
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .pgm_n     (pgm_n),
        .vpp_hi    (vpp_hi),
        .a9_hv     (a9_hv),
        .mode      (mode),
        .drive_req (drive_req),
        .wr_en     (wr_en),
        .ident_sel (ident_sel)
    );

    eprom_array #(.AW(AW), .DW(DW)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (din),
        .rd_data (arr_rd)
    );

    assign rd_sel = ident_sel ? (addr[0] ? DEV_ID : MFR_ID) : arr_rd;
    assign key    = {mode, addr};

    eprom_out_fsm #(
        .DW(DW), .KW(KW), .ACCESS_CYC(ACCESS_CYC), .FLOAT_CYC(FLOAT_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .drive_req (drive_req),
        .key       (key),
        .rd_sel    (rd_sel),
        .dout      (dout),
        .dout_en   (dout_en)
    );
endmodule

// File: rtl/eprom_mode_chk.sv
module eprom_mode_chk #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          ce_n,
    input logic          oe_n,
    input logic          pgm_n,
    input logic          vpp_hi,
    input logic [DW-1:0] dout,
    input logic          dout_en,
    input logic [DW-1:0] arr_rd
);
    logic armed;
    logic prog_pins;

    assign prog_pins = !ce_n && oe_n && !pgm_n && vpp_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2: the bus only turns on after a data-returning pin pattern was sampled
    a_r2_rise_needs_data_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $rose(dout_en)) |-> $past(!ce_n && !oe_n && pgm_n));

    // R3: a stored byte never gains a one bit
    a_r3_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && addr == $past(addr)) |-> ((arr_rd & ~$past(arr_rd)) == '0));

    // R5, R6: outside program mode the addressed byte stays as it was
    a_r6_no_write_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && addr == $past(addr) && !$past(prog_pins)) |-> (arr_rd == $past(arr_rd)));

    // R5: chip enable high never starts driving
    a_r5_no_rise_ce_high: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(ce_n)) |-> !$rose(dout_en));

    // R9: data held while the bus stays enabled
    a_r9_hold_while_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dout_en && $past(dout_en)) |-> (dout == $past(dout)));
endmodule

bind eprom_mode_model eprom_mode_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .pgm_n   (pgm_n),
    .vpp_hi  (vpp_hi),
    .dout    (dout),
    .dout_en (dout_en),
    .arr_rd  (arr_rd)
);

// File: tb/eprom_mode_model_tb.sv
module eprom_mode_model_tb;
    localparam int AW  = 13;
    localparam int DW  = 8;
    localparam int ACC = 3;
    localparam int FLT = 2;
    localparam logic [7:0] MFR = 8'hA5;
    localparam logic [7:0] DEV = 8'h3C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0, a9_hv = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    always #10 clk = ~clk;

    eprom_mode_model #(.AW(AW), .DW(DW), .ACCESS_CYC(ACC), .FLOAT_CYC(FLT),
                       .MFR_ID(MFR), .DEV_ID(DEV)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .pgm_n(pgm_n), .vpp_hi(vpp_hi), .a9_hv(a9_hv), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // Behavioural reference: store contents, consecutive-cycle counts.
    logic [7:0] ref_mem [0:8191];
    int   run = 0, flt = 0, prev_key = -1;
    bit   prev_drive = 0, prev_valid = 0, exp_en = 0;
    logic [7:0] exp_data = '0;

    initial for (int i = 0; i < 8192; i++) ref_mem[i] = 8'hFF;

    // 0 read, 1 program, 2 verify, 3 inhibit, 4 standby, 5 outdis, 6 ident, 7 other
    function automatic int pin_mode();
        if (ce_n) return vpp_hi ? 3 : 4;
        if (vpp_hi) begin
            if (oe_n && !pgm_n) return 1;
            if (!oe_n && pgm_n) return 2;
            return 7;
        end
        if (oe_n && pgm_n) return 5;
        if (!oe_n && pgm_n) return a9_hv ? 6 : 0;
        return 7;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            run = 0; flt = 0; exp_en = 0; prev_drive = 0; prev_valid = 0; prev_key = -1;
            for (int i = 0; i < 8192; i++) ref_mem[i] = 8'hFF;
        end else begin
            int m, k;
            bit drv;
            m   = pin_mode();
            drv = (m == 0) || (m == 2) || (m == 6);
            k   = m * 8192 + int'(addr);
            if (drv) begin
                flt = 0;
                if (prev_drive && k == prev_key) run++;
                else run = 1;
                if (run == ACC + 1)
                    exp_data = (m == 6) ? (addr[0] ? DEV : MFR) : ref_mem[addr];
                exp_en = (run > ACC);
            end else begin
                run = 0;
                if (prev_valid) flt = FLT;
                else if (flt > 0) flt--;
                exp_en = (flt > 0);
            end
            prev_valid = drv && (run > ACC);
            prev_drive = drv;
            prev_key   = k;
            if (m == 1) ref_mem[addr] = ref_mem[addr] & din;
        end
    end

    always @(negedge clk) begin
        checks++;
        if (dout_en !== exp_en) begin
            errors++;
            $display("FAIL %s dout_en actual %0b expected %0b at %0t", cur_req, dout_en, exp_en, $time);
        end else if (exp_en) begin
            checks++;
            if (dout !== exp_data) begin
                errors++;
                $display("FAIL %s dout actual %02h expected %02h at %0t", cur_req, dout, exp_data, $time);
            end
        end
    end

    task automatic pins(input logic c, input logic o, input logic p, input logic v,
                        input logic a9, input int a, input logic [7:0] d, input int n);
        @(negedge clk);
        ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; a9_hv = a9;
        addr = AW'(a); din = d;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic rd(input int a, input int n);   pins(0, 0, 1, 0, 0, a, 8'h00, n); endtask
    task automatic prog(input int a, input logic [7:0] d, input int n); pins(0, 1, 0, 1, 0, a, d, n); endtask
    task automatic idle(input int n);               pins(1, 1, 1, 0, 0, 0, 8'h00, n); endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired, run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        rd(0, 6); rd(8191, 6); rd(4096, 6);

        cur_req = "R3";
        prog(12'h123, 8'h5A, 3);
        prog(12'h123, 8'hF0, 2);
        prog(8191, 8'h81, 2);
        prog(0, 8'h7E, 2);
        idle(3);

        cur_req = "R4";
        pins(0, 0, 1, 1, 0, 12'h123, 8'h00, 6);
        pins(0, 0, 1, 1, 1, 8191, 8'h00, 6);

        cur_req = "R2";
        rd(12'h123, 6); rd(0, 5); rd(1, 5); rd(8191, 6); rd(0, 6);
        for (int i = 0; i < 8; i++) rd((i * 1237 + 5) % 8192, 2);
        for (int i = 0; i < 10; i++) rd((i * 3001 + 17) % 8192, 5);

        cur_req = "R7";
        pins(0, 0, 1, 0, 1, 0, 8'h00, 6);
        pins(0, 0, 1, 0, 1, 1, 8'h00, 6);
        pins(0, 0, 1, 0, 1, 13'h1FFE, 8'h00, 6);
        pins(0, 0, 1, 0, 0, 13'h1FFE, 8'h00, 6);

        cur_req = "R5";
        pins(1, 0, 1, 0, 0, 12'h200, 8'h00, 4);
        pins(1, 1, 0, 1, 0, 12'h200, 8'h00, 4);
        pins(1, 0, 0, 1, 0, 12'h200, 8'h00, 4);
        rd(12'h200, 6);

        cur_req = "R6";
        pins(0, 1, 1, 0, 0, 12'h300, 8'h00, 4);
        pins(0, 1, 0, 0, 0, 12'h300, 8'h00, 4);
        pins(0, 0, 0, 1, 0, 12'h300, 8'h00, 4);
        pins(0, 0, 0, 0, 0, 12'h300, 8'h00, 4);
        rd(12'h300, 6);

        cur_req = "R8";
        rd(12'h123, 6);
        pins(0, 1, 1, 0, 0, 12'h123, 8'h00, 1);
        rd(12'h123, 6);
        pins(0, 1, 1, 0, 0, 12'h123, 8'h00, 2);
        rd(8191, 6);
        pins(1, 1, 1, 0, 0, 0, 8'h00, 5);

        cur_req = "R9";
        rd(12'h123, 12);
        prog(12'h123, 8'h0F, 1);
        pins(0, 0, 1, 1, 0, 12'h123, 8'h00, 6);
        idle(5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule